// File: doc/BRIEF.md
# Level-Match GPIO Controller

This block gives a processor register-level control over a bank of general-purpose pins. Each pin is either handed to an on-chip alternate function, which then owns the pad's output value and output enable, or kept as a GPIO. A GPIO pin is either an input or an output driven from a data register. Pin values pass through a two-flop synchroniser before software reads them or the interrupt logic compares them.

Every pin has a programmable level. When a pin's synchronised value equals that level, the pin's status bit is set, and it stays set until software clears it. A per-pin routing register sends a pending status either to the pin's own interrupt line or to one shared non-maskable interrupt output.

All registers sit behind a small word-addressed bus with a one-cycle read latency. The pad and interrupt outputs come straight from flops.

Top module: `gpm_ctrl`

## Requirements
- R1: Registers are decoded from the word index `reg_addr[4:2]` as follows: 0 = function select, 1 = direction, 2 = data, 3 = interrupt level, 4 = interrupt status, 5 = non-maskable routing enable. Indices 6 and 7 are unmapped. An address whose bits [1:0] are not 00 is also unmapped. A read of an unmapped address returns 0, and a write to one changes no register. `reg_rdata` is loaded at the clock edge where `reg_rd` is high.
- R2: A function-select bit of 1 hands the pin to its alternate function: `pad_out` and `pad_oe` take `alt_out` and `alt_oe` for that pin, one edge later.
- R3: With the function-select bit at 0, the pin's direction bit sets `pad_oe` (0 = input, 1 = output), and `pad_out` carries the pin's data-register bit.
- R4: A read of the data register returns the synchronised state of every pad. A write sets the value driven on GPIO output pins.
- R5: A change on `pad_in` reaches the data read-back and the level compare only after two clock edges. A read issued in the same cycle as the change, or one cycle after it, still returns the old value.
- R6: A status bit is set at each edge where the pin's synchronised value equals its level bit. This holds for both level values, 0 and 1.
- R7: Status bits are sticky. In a status write, a 0 clears the bit and a 1 leaves it unchanged. Nothing else clears a status bit.
- R8: If a status bit is cleared while its match condition still holds, the bit remains 1.
- R9: `irq_nmi` is the OR of the status bits whose routing bit is 1. `irq_pin[x]` is status bit x when routing bit x is 0, and 0 otherwise.
- R10: Reset clears every register. All pins become GPIO inputs, `pad_oe` is 0, and no interrupt output is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ABITS (5) | Byte address |
| reg_wdata | input | N (32) | Write data |
| reg_rdata | output | N (32) | Read data, valid the cycle after `reg_rd` |
| pad_in | input | N (32) | Pad input values |
| pad_out | output | N (32) | Pad output values |
| pad_oe | output | N (32) | Pad output enables |
| alt_out | input | N (32) | Alternate-function output values |
| alt_oe | input | N (32) | Alternate-function output enables |
| irq_pin | output | N (32) | Per-pin interrupt lines |
| irq_nmi | output | 1 | Non-maskable interrupt |

## Verification
The bound checker watches four things on every cycle:
- Each status bit holds unless a status write occurs.
- A match always leaves its bit set, and a status write gives exactly keep-or-match.
- Both interrupt outputs follow status and routing.
- Pad enables follow function select and direction.

Some behaviours can only be shown by the bench's scenarios:
- The exact two-edge synchroniser latency.
- The pad muxing under mixed configurations, with looped-back outputs.
- Whether unmapped addresses disturb the registers.
- The reset values that software reads back.

// File: rtl/gpm_pkg.sv
package gpm_pkg;
  typedef enum logic [2:0] {
    RI_FUNC  = 3'd0,
    RI_DIR   = 3'd1,
    RI_DATA  = 3'd2,
    RI_LVL   = 3'd3,
    RI_STAT  = 3'd4,
    RI_NMIEN = 3'd5
  } reg_idx_e;

  localparam int NREGS = 6;
endpackage

// File: rtl/gpm_sync.sv
module gpm_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  // Stage 0 samples the raw input; each later stage samples the one before it.
  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[k] <= '0;
        else     stg[k] <= stg[k-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpm_regfile.sv
module gpm_regfile
  import gpm_pkg::*;
#(
  parameter int N     = 32,
  parameter int ABITS = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             rd,
  input  logic [ABITS-1:0] addr,
  input  logic [N-1:0]     wdata,
  output logic [N-1:0]     rdata,
  input  logic [N-1:0]     pin_sync,
  input  logic [N-1:0]     stat_q,
  output logic [N-1:0]     sel_q,
  output logic [N-1:0]     dir_q,
  output logic [N-1:0]     lvl_q,
  output logic [N-1:0]     en_q,
  output logic [N-1:0]     sel_d,
  output logic [N-1:0]     dir_d,
  output logic [N-1:0]     data_d,
  output logic [N-1:0]     en_d,
  output logic             stat_wr
);
  localparam int IW = ABITS - 2;

  logic [IW-1:0] idx;
  logic          aligned;
  logic [N-1:0]  data_q;
  logic [N-1:0]  lvl_d;
  logic [N-1:0]  rmux;

  assign idx     = addr[ABITS-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  function automatic logic hit_idx(input logic [IW-1:0] i, input reg_idx_e r);
    return i == IW'(r);
  endfunction

  // Next-state values of the stored registers.
  always_comb begin
    sel_d  = sel_q;
    dir_d  = dir_q;
    data_d = data_q;
    lvl_d  = lvl_q;
    en_d   = en_q;
    if (wr && aligned) begin
      if (hit_idx(idx, RI_FUNC))  sel_d  = wdata;
      if (hit_idx(idx, RI_DIR))   dir_d  = wdata;
      if (hit_idx(idx, RI_DATA))  data_d = wdata;
      if (hit_idx(idx, RI_LVL))   lvl_d  = wdata;
      if (hit_idx(idx, RI_NMIEN)) en_d   = wdata;
    end
  end

  assign stat_wr = wr && aligned && hit_idx(idx, RI_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      dir_q  <= '0;
      data_q <= '0;
      lvl_q  <= '0;
      en_q   <= '0;
    end else begin
      sel_q  <= sel_d;
      dir_q  <= dir_d;
      data_q <= data_d;
      lvl_q  <= lvl_d;
      en_q   <= en_d;
    end
  end

  // Read multiplexer. Unmapped or misaligned addresses read as 0.
  always_comb begin
    rmux = '0;
    if (aligned) begin
      if (hit_idx(idx, RI_FUNC))  rmux = sel_q;
      if (hit_idx(idx, RI_DIR))   rmux = dir_q;
      if (hit_idx(idx, RI_DATA))  rmux = pin_sync;
      if (hit_idx(idx, RI_LVL))   rmux = lvl_q;
      if (hit_idx(idx, RI_STAT))  rmux = stat_q;
      if (hit_idx(idx, RI_NMIEN)) rmux = en_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rmux;
  end
endmodule

// File: rtl/gpm_status.sv
module gpm_status #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_sync,
  input  logic [N-1:0] lvl_q,
  input  logic         stat_wr,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] en_d,
  output logic [N-1:0] stat_q,
  output logic [N-1:0] irq_pin,
  output logic         irq_nmi
);
  logic [N-1:0] hit;
  logic [N-1:0] keep;
  logic [N-1:0] stat_d;

  assign hit    = ~(pin_sync ^ lvl_q);
  assign keep   = stat_wr ? wdata : '1;
  assign stat_d = (stat_q & keep) | hit;

  // Interrupt outputs are registered from the next-state values, so they
  // line up with stat_q and the routing register in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= '0;
      irq_pin <= '0;
      irq_nmi <= 1'b0;
    end else begin
      stat_q  <= stat_d;
      irq_pin <= stat_d & ~en_d;
      irq_nmi <= |(stat_d & en_d);
    end
  end
endmodule

// File: rtl/gpm_padmux.sv
module gpm_padmux #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sel_d,
  input  logic [N-1:0] dir_d,
  input  logic [N-1:0] data_d,
  input  logic [N-1:0] alt_out,
  input  logic [N-1:0] alt_oe,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[i] <= 1'b0;
        pad_oe[i]  <= 1'b0;
      end else if (sel_d[i]) begin
        pad_out[i] <= alt_out[i];
        pad_oe[i]  <= alt_oe[i];
      end else begin
        pad_out[i] <= data_d[i];
        pad_oe[i]  <= dir_d[i];
      end
    end
  end
endmodule

// File: rtl/gpm_ctrl.sv
module gpm_ctrl #(
  parameter int N     = 32,
  parameter int ABITS = 5,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [ABITS-1:0] reg_addr,
  input  logic [N-1:0]     reg_wdata,
  output logic [N-1:0]     reg_rdata,
  input  logic [N-1:0]     pad_in,
  output logic [N-1:0]     pad_out,
  output logic [N-1:0]     pad_oe,
  input  logic [N-1:0]     alt_out,
  input  logic [N-1:0]     alt_oe,
  output logic [N-1:0]     irq_pin,
  output logic             irq_nmi
);
  logic [N-1:0] pin_sync;
  logic [N-1:0] stat_q;
  logic [N-1:0] sel_q, dir_q, lvl_q, en_q;
  logic [N-1:0] sel_d, dir_d, data_d, en_d;
  logic         stat_wr;

  gpm_sync #(.W(N), .STAGES(SYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (pad_in),
    .dout(pin_sync)
  );

  gpm_regfile #(.N(N), .ABITS(ABITS)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr      (reg_wr),
    .rd      (reg_rd),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .pin_sync(pin_sync),
    .stat_q  (stat_q),
    .sel_q   (sel_q),
    .dir_q   (dir_q),
    .lvl_q   (lvl_q),
    .en_q    (en_q),
    .sel_d   (sel_d),
    .dir_d   (dir_d),
    .data_d  (data_d),
    .en_d    (en_d),
    .stat_wr (stat_wr)
  );

  gpm_status #(.N(N)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .pin_sync(pin_sync),
    .lvl_q   (lvl_q),
    .stat_wr (stat_wr),
    .wdata   (reg_wdata),
    .en_d    (en_d),
    .stat_q  (stat_q),
    .irq_pin (irq_pin),
    .irq_nmi (irq_nmi)
  );

  gpm_padmux #(.N(N)) u_pads (
    .clk    (clk),
    .rst    (rst),
    .sel_d  (sel_d),
    .dir_d  (dir_d),
    .data_d (data_d),
    .alt_out(alt_out),
    .alt_oe (alt_oe),
    .pad_out(pad_out),
    .pad_oe (pad_oe)
  );
endmodule

// File: rtl/gpm_chk.sv
module gpm_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] sel_q,
  input logic [N-1:0] dir_q,
  input logic [N-1:0] lvl_q,
  input logic [N-1:0] en_q,
  input logic [N-1:0] stat_q,
  input logic [N-1:0] pin_sync,
  input logic         stat_wr,
  input logic [N-1:0] wdata,
  input logic [N-1:0] alt_oe,
  input logic [N-1:0] pad_oe,
  input logic [N-1:0] irq_pin,
  input logic         irq_nmi
);
  // R7: without a status write, no set bit is lost
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(stat_wr) |-> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R6: a match seen at an edge leaves the bit set
  p_match_sets_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~($past(pin_sync) ^ $past(lvl_q))) == ~($past(pin_sync) ^ $past(lvl_q))));

  // R8: a status write gives keep-or-match, with match taking priority
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $past(stat_wr) |-> (stat_q == (($past(stat_q) & $past(wdata)) | ~($past(pin_sync) ^ $past(lvl_q)))));

  // R9: shared non-maskable line
  p_nmi_r9: assert property (@(posedge clk) disable iff (rst)
    irq_nmi == (|(stat_q & en_q)));

  // R9: per-pin lines carry only the unrouted status bits
  p_pin_irq_r9: assert property (@(posedge clk) disable iff (rst)
    irq_pin == (stat_q & ~en_q));

  // R2, R3: pad enable follows function select and direction
  p_oe_r3: assert property (@(posedge clk) disable iff (rst)
    pad_oe == ((sel_q & $past(alt_oe)) | (~sel_q & dir_q)));
endmodule

bind gpm_ctrl gpm_chk #(.N(N)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .sel_q   (sel_q),
  .dir_q   (dir_q),
  .lvl_q   (lvl_q),
  .en_q    (en_q),
  .stat_q  (stat_q),
  .pin_sync(pin_sync),
  .stat_wr (stat_wr),
  .wdata   (reg_wdata),
  .alt_oe  (alt_oe),
  .pad_oe  (pad_oe),
  .irq_pin (irq_pin),
  .irq_nmi (irq_nmi)
);

// File: tb/sim_gpm_ctrl.sv
module sim_gpm_ctrl;
  localparam int N = 32;
  localparam int ABITS = 5;
  localparam logic [N-1:0] AOUT = 32'hF0F0_F0F0;
  localparam logic [N-1:0] AOE  = 32'hFF00_FF00;
  localparam logic [ABITS-1:0] A_FUNC = 5'h00, A_DIR = 5'h04, A_DATA = 5'h08,
                               A_LVL = 5'h0C, A_STAT = 5'h10, A_NMI = 5'h14;

  // Each entry: {function select, direction, data, external pin drive}
  localparam logic [127:0] VEC [6] = '{
    {32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678},
    {32'h0000_0000, 32'hFFFF_FFFF, 32'hA5A5_A5A5, 32'h0000_0000},
    {32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0F0F_0F0F},
    {32'hFFFF_0000, 32'h0000_FFFF, 32'h0000_3C3C, 32'h5555_5555},
    {32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'h1234_5678, 32'h89AB_CDEF},
    {32'h0000_0000, 32'h0000_FFFF, 32'hDEAD_BEEF, 32'hCAFE_0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [ABITS-1:0] reg_addr = '0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata, pad_in, pad_out, pad_oe, irq_pin;
  logic [N-1:0] ext_in = '0;
  logic irq_nmi;
  logic [N-1:0] rv;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_in);

  gpm_ctrl #(.N(N), .ABITS(ABITS), .SYNC(2)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .alt_out(AOUT), .alt_oe(AOE), .irq_pin(irq_pin), .irq_nmi(irq_nmi)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ABITS-1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [ABITS-1:0] a, output logic [N-1:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [N-1:0] s, d, e, x, oe, po;
    idle(3);
    // R10: outputs quiet while reset is held
    check("R10 pad_oe", pad_oe, '0);
    check("R10 irq_pin", irq_pin, '0);
    check("R10 irq_nmi", {31'b0, irq_nmi}, '0);
    check("R10 rdata", reg_rdata, '0);
    rst = 1'b0;
    rd(A_FUNC, rv); check("R10 func", rv, '0);
    rd(A_DIR, rv);  check("R10 dir", rv, '0);
    rd(A_LVL, rv);  check("R10 lvl", rv, '0);
    rd(A_NMI, rv);  check("R10 nmi enable", rv, '0);

    // R2 R3 R4: vector table for pad muxing and data read-back
    for (int v = 0; v < 6; v++) begin
      {s, d, d, x} = VEC[v];
      s = VEC[v][127:96]; e = VEC[v][95:64]; d = VEC[v][63:32]; x = VEC[v][31:0];
      ext_in = x;
      wr(A_FUNC, s); wr(A_DIR, e); wr(A_DATA, d);
      idle(3);
      oe = (s & AOE) | (~s & e);
      po = (s & AOUT) | (~s & d);
      check("R3 pad_oe", pad_oe, oe);
      check("R2 pad_out", pad_out, po);
      rd(A_DATA, rv);
      check("R4 data readback", rv, (oe & po) | (~oe & x));
    end

    // Back to GPIO inputs, level all ones, pins low: no matches.
    wr(A_FUNC, '0); wr(A_DIR, '0); wr(A_LVL, '1);
    ext_in = '0; idle(3);
    wr(A_STAT, '0);
    rd(A_STAT, rv); check("R7 cleared", rv, '0);

    // R6 R7: a short pulse on pin 3 leaves a sticky bit
    ext_in = 32'h8; idle(4); ext_in = '0; idle(4);
    rd(A_STAT, rv); check("R7 sticky after pulse", rv, 32'h8);
    check("R9 irq_pin", irq_pin, 32'h8);
    check("R9 irq_nmi low", {31'b0, irq_nmi}, '0);
    wr(A_STAT, '1);
    rd(A_STAT, rv); check("R7 write one keeps", rv, 32'h8);
    wr(A_STAT, 32'hFFFF_FFF7);
    rd(A_STAT, rv); check("R7 write zero clears", rv, '0);
    check("R9 irq_pin cleared", irq_pin, '0);

    // R8: clearing while the match persists
    ext_in = 32'h8; idle(4);
    wr(A_STAT, '0);
    rd(A_STAT, rv); check("R8 set wins", rv, 32'h8);

    // R9: route pin 3 to the non-maskable output
    wr(A_NMI, 32'h8);
    check("R9 irq_nmi high", {31'b0, irq_nmi}, 32'h1);
    check("R9 irq_pin routed away", irq_pin, '0);
    rd(A_NMI, rv); check("R1 nmi enable readback", rv, 32'h8);
    ext_in = '0; idle(4);
    wr(A_STAT, '0);
    check("R9 irq_nmi after clear", {31'b0, irq_nmi}, '0);

    // R6: a level bit of 0 matches a low pin
    wr(A_LVL, 32'hFFFF_FFFE); idle(3);
    rd(A_STAT, rv); check("R6 low-level match", rv, 32'h1);
    check("R6 irq_pin bit0", irq_pin, 32'h1);

    // R5: two-edge synchroniser latency
    @(negedge clk);
    ext_in = 32'hF0; reg_rd = 1'b1; reg_addr = A_DATA;
    @(negedge clk); check("R5 same cycle old", reg_rdata, '0);
    @(negedge clk); check("R5 one edge old", reg_rdata, '0);
    @(negedge clk); check("R5 two edges new", reg_rdata, 32'hF0);
    reg_rd = 1'b0;

    // R1: unmapped and misaligned addresses
    rd(5'h18, rv); check("R1 unmapped 6", rv, '0);
    rd(5'h1C, rv); check("R1 unmapped 7", rv, '0);
    rd(5'h0D, rv); check("R1 misaligned read", rv, '0);
    wr(5'h18, '1); wr(5'h1C, '1); wr(5'h05, '1);
    rd(A_FUNC, rv); check("R1 func untouched", rv, '0);
    rd(A_DIR, rv);  check("R1 dir untouched", rv, '0);
    rd(A_LVL, rv);  check("R1 lvl untouched", rv, 32'hFFFF_FFFE);
    rd(A_NMI, rv);  check("R1 nmi untouched", rv, 32'h8);
    check("R1 pad_oe untouched", pad_oe, '0);

    done = 1'b1;
    finish_run();
  end
endmodule